// File: doc/BRIEF.md
# Prescaled Modulo Event Timer

This block is a register-mapped up-counter that produces periodic or one-shot events. The counter advances on ticks derived from the system clock through a power-of-two prescaler. When it reaches the programmed modulo value, the next tick reloads it with a programmable start value and sets a sticky overflow flag. That flag, gated by an enable bit, drives a level interrupt.

Software programs the timer through four word registers on a simple strobe bus:

| Address | Register |
|---|---|
| 0 | control/status |
| 1 | counter |
| 2 | modulo |
| 3 | start value |

The modulo and start registers are written into holding buffers. Their contents reach the active copies only while counting is switched off, so a running period is never disturbed mid-flight. A period of N ticks is obtained with a modulo value of N-1. Writing the counter register restarts the count from the active start value, whatever data is written.

The control/status layout is:

| Bits | Field |
|---|---|
| [2:0] | prescale exponent |
| [4:3] | source select |
| [5] | interrupt enable |
| [6] | overflow flag |

Top module: `modulo_tick_timer`

## Requirements
- R1: While counting, each tick raises the counter by one as long as the counter differs from the active modulo value.
- R2: On a tick with the counter equal to the active modulo value, the counter takes the active start value and the overflow flag (control bit 6) is set in that same clock edge. With start value S and modulo value M, an overflow occurs every M-S+1 ticks, including 65536 ticks for S=0 and M=0xFFFF.
- R3: A write to address 1 loads the counter with the active start value, the written data is discarded, and this write takes priority over a tick in the same cycle.
- R4: Writes to address 2 (modulo) and address 3 (start) land in buffers that read back at once. A buffer is copied to its active register on each clock edge where the source select field (bits [4:3]) is not 1, so a write made while counting has no effect on the running period.
- R5: Source select value 1 counts from the system clock. Values 0, 2 and 3 hold the counter still.
- R6: The prescale exponent P (bits [2:0]) gives one tick per 2^P clock cycles. The divider is cleared while counting is off, so the first tick comes 2^P cycles after the edge that enables counting.
- R7: The irq output is high exactly when both the overflow flag and the interrupt enable (bit 5) are set. Clearing the enable drops irq while the flag stays readable.
- R8: A control write with bit 6 at 0 clears the overflow flag, and with bit 6 at 1 leaves it unchanged. An overflow in the same cycle as a clearing write keeps the flag set.
- R9: After reset the control register, counter and start value read 0, the modulo value reads 0xFFFF, and irq is low.
- R10: A read strobe captures the addressed register into rd_data on that clock edge, where it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the counting source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 2 | Register select: 0 control, 1 counter, 2 modulo, 3 start |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Registered read data |
| irq | output | 1 | Overflow interrupt, level |

## Verification
A fault in the prescaler divider or in the active modulo and start copies does not show until the next overflow, which can be up to 65536 times 128 cycles away. For that reason the bench reads the counter at exactly computed cycle offsets after enabling, which exposes a wrong step size or a late first tick within a few ticks. A stale active modulo value shows as irq rising one full period early or late. A sticky-flag error shows in the single cycle after a clearing write, because irq follows the flag with no delay. Buffer writes made while running are followed through a whole period, so an early copy into the active register turns into a visibly short period.

// File: rtl/modulo_tick_timer.sv
module modulo_tick_timer #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq
);
  localparam int DIV_W   = (1 << PS_W) - 1;
  localparam int SEL_LSB = PS_W;
  localparam int IE_BIT  = PS_W + 2;
  localparam int TOF_BIT = PS_W + 3;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_MOD = 2'd2, A_INIT = 2'd3;
  localparam logic [1:0] SEL_SYS = 2'd1;

  logic [PS_W-1:0]  ps_q;
  logic [1:0]       sel_q;
  logic             ie_q, tof_q;
  logic [CNT_W-1:0] cnt_q, mod_buf, mod_act, init_buf, init_act;
  logic [DIV_W-1:0] div_q, div_mask;
  logic             run, tick, wrap, ctrl_wr, cnt_wr;
  logic [CNT_W-1:0] ctrl_view, rd_mux;

  assign run      = (sel_q == SEL_SYS);
  assign div_mask = ~({DIV_W{1'b1}} << ps_q);
  assign tick     = run && ((div_q & div_mask) == div_mask);
  assign wrap     = tick && (cnt_q == mod_act);
  assign ctrl_wr  = wr_en && (addr == A_CTRL);
  assign cnt_wr   = wr_en && (addr == A_CNT);
  assign irq      = tof_q & ie_q;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[PS_W-1:0]            = ps_q;
    ctrl_view[SEL_LSB+1:SEL_LSB]   = sel_q;
    ctrl_view[IE_BIT]              = ie_q;
    ctrl_view[TOF_BIT]             = tof_q;
    case (addr)
      A_CTRL:  rd_mux = ctrl_view;
      A_CNT:   rd_mux = cnt_q;
      A_MOD:   rd_mux = mod_buf;
      default: rd_mux = init_buf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      sel_q <= '0;
      ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      ps_q  <= wr_data[PS_W-1:0];
      sel_q <= wr_data[SEL_LSB+1:SEL_LSB];
      ie_q  <= wr_data[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tof_q <= 1'b0;
    else if (wrap)    tof_q <= 1'b1;
    else if (ctrl_wr) tof_q <= tof_q & wr_data[TOF_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
    else          div_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_buf  <= '1;
      init_buf <= '0;
    end else if (wr_en) begin
      if (addr == A_MOD)  mod_buf  <= wr_data;
      if (addr == A_INIT) init_buf <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_act  <= '1;
      init_act <= '0;
    end else if (!run) begin
      mod_act  <= mod_buf;
      init_act <= init_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_wr) cnt_q <= init_act;
    else if (wrap)   cnt_q <= init_act;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/modulo_tick_timer_chk.sv
module modulo_tick_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [1:0]       sel,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_act,
  input logic [CNT_W-1:0] init_act,
  input logic             tof,
  input logic             ie,
  input logic             irq
);
  localparam int TOF_BIT = PS_W + 3;
  logic cnt_wr, clr_wr, on;
  assign cnt_wr = wr_en && (addr == 2'd1);
  assign clr_wr = wr_en && (addr == 2'd0) && !wr_data[TOF_BIT];
  assign on     = (sel == 2'd1);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != mod_act && !cnt_wr) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt == mod_act && !cnt_wr) |=> (tof && cnt == $past(init_act))); // R2
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(init_act)); // R3
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    on |=> (mod_act == $past(mod_act) && init_act == $past(init_act))); // R4
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!on && !cnt_wr) |=> $stable(cnt)); // R5
  AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> !tick); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(tof) || $rose(ie))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tof && !clr_wr) |=> tof); // R8
endmodule

bind modulo_tick_timer modulo_tick_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .sel(sel_q), .tick(tick), .cnt(cnt_q), .mod_act(mod_act), .init_act(init_act),
  .tof(tof_q), .ie(ie_q), .irq(irq));

// File: tb/modulo_tick_timer_tb_top.sv
`timescale 1ns/1ps
module modulo_tick_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modulo_tick_timer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic load(input logic [15:0] s, input logic [15:0] m);
    wr(2'd0, 16'h0000);
    wr(2'd3, s);
    wr(2'd2, m);
    idle(1);
    wr(2'd1, 16'h0000);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check({15'd0, irq}, 16'd0, "R9 irq");
    rd(2'd0, v); check(v, 16'h0000, "R9 ctrl");
    rd(2'd1, v); check(v, 16'h0000, "R9 counter");
    rd(2'd2, v); check(v, 16'hFFFF, "R9 modulo");
    rd(2'd3, v); check(v, 16'h0000, "R9 start");
  endtask

  task automatic t_count;
    logic [15:0] v;
    load(16'h0010, 16'hFFFF);
    wr(2'd0, 16'h0008);
    rd(2'd1, v); check(v, 16'h0010, "R10 first read");
    rd(2'd1, v); check(v, 16'h0011, "R1 step");
    idle(5);
    rd(2'd1, v); check(v, 16'h0017, "R1 steps");
    wr(2'd1, 16'hABCD);
    rd(2'd1, v); check(v, 16'h0010, "R3 reload ignores data");
  endtask

  task automatic t_stop;
    logic [15:0] v, w;
    wr(2'd0, 16'h0010);
    rd(2'd1, v);
    idle(6);
    rd(2'd1, w); check(w, v, "R5 select 2 holds");
    wr(2'd0, 16'h0000);
    idle(6);
    rd(2'd1, v); check(v, w, "R5 select 0 holds");
  endtask

  task automatic t_prescale;
    logic [15:0] v;
    load(16'h0000, 16'hFFFF);
    wr(2'd0, 16'h000A);
    idle(9);
    rd(2'd1, v); check(v, 16'h0002, "R6 divide by 4");
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h000A);
    idle(3);
    rd(2'd1, v); check(v, 16'h0000, "R6 no early tick");
    rd(2'd1, v); check(v, 16'h0001, "R6 first tick after 4");
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    load(16'h0005, 16'h0009);
    wr(2'd0, 16'h0028);
    idle(4); check({15'd0, irq}, 16'd0, "R2 before wrap");
    idle(1); check({15'd0, irq}, 16'd1, "R2 wrap after 5 ticks");
    idle(4);
    wr(2'd0, 16'h0028);
    check({15'd0, irq}, 16'd1, "R8 overflow wins");
    wr(2'd0, 16'h0028);
    check({15'd0, irq}, 16'd0, "R8 clear");
    wr(2'd0, 16'h0068);
    check({15'd0, irq}, 16'd0, "R8 write 1 no set");
    idle(3); check({15'd0, irq}, 16'd1, "R2 next period");
    wr(2'd0, 16'h0048);
    check({15'd0, irq}, 16'd0, "R7 enable off");
    rd(2'd0, v); check(v, 16'h0048, "R7 flag kept");
  endtask

  task automatic t_buffer;
    logic [15:0] v;
    load(16'h0000, 16'h0009);
    wr(2'd0, 16'h0028);
    wr(2'd2, 16'h0003);
    idle(3); check({15'd0, irq}, 16'd0, "R4 buffer not active");
    idle(6); check({15'd0, irq}, 16'd1, "R4 old period kept");
    rd(2'd2, v); check(v, 16'h0003, "R4 buffer readback");
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0028);
    idle(3); check({15'd0, irq}, 16'd0, "R4 new period early");
    idle(1); check({15'd0, irq}, 16'd1, "R4 new period");
  endtask

  task automatic t_full;
    load(16'h0000, 16'hFFFF);
    wr(2'd0, 16'h0028);
    idle(65535); check({15'd0, irq}, 16'd0, "R2 full before");
    idle(1); check({15'd0, irq}, 16'd1, "R2 full 65536");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_count;
    t_stop;
    t_prescale;
    t_overflow;
    t_buffer;
    t_full;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule